// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address and count engine of one DMA channel. Once enabled it presents a current memory address and asks for one element transfer at a time. Each accepted transfer moves the address by a signed X stride and counts down the elements left in the current row. When a row ends, the engine does one of three things. In two-dimensional mode, if rows remain, it moves to the next row using a Y stride. Otherwise, in stop mode, it ends the work with a done flag. In any other flow mode it asks an external fetcher for the next descriptor.

The bus transfer itself happens outside the block, through the `elem_req`/`elem_ack` handshake. The descriptor fetch also happens outside, through the `desc_req`/`desc_ack` handshake: the fetcher updates the configuration inputs and then pulses `desc_ack`. The engine can raise a one-cycle interrupt at the end of every row. The configuration inputs are read live, so they must stay steady while the engine is busy, except during a descriptor reload.

Top module: `dma2d_addr_gen`

## Requirements
- R1: An element is accepted on a cycle where `elem_req` and `elem_ack` are both high. A non-final element of a row adds the sign-extended `cfg_x_mod` to `mem_addr` and decrements `cur_x_count` by one, visible on the next cycle.
- R2: When the accepted element is the last of a row (`cur_x_count` was 1) and `cfg_irq_en` is 1, `row_irq` is high for exactly the following cycle.
- R3: With `cfg_two_d`=1 and `cur_y_count` above 1, the last element of a row decrements `cur_y_count`, reloads `cur_x_count` from `cfg_x_count`, and sets `mem_addr` to the old address plus X stride, minus X stride, plus the sign-extended `cfg_y_mod`.
- R4: When no row remains and `cfg_flow`=0 (stop), the last element sets `mem_addr` to address plus X stride, sets `cur_x_count` to 0, drops `busy` and raises `done`. `done` stays high until the next start.
- R5: When no row remains and `cfg_flow` is nonzero, the engine updates the address the same way, sets `cur_x_count` to 0 and holds `desc_req` high until `desc_ack`. On `desc_ack` it reloads `mem_addr` from `cfg_start_addr` and both counts from the configuration, then resumes requesting elements.
- R6: `mem_write` captures `cfg_dir` at start and at each descriptor reload. A value of 1 means peripheral-to-memory (memory write); 0 means memory-to-peripheral (memory read).
- R7: Both strides are 16-bit two's-complement values sign-extended to the address width, so 16'hFFFC moves the address down by 4.
- R8: While `desc_req` is high, `elem_req` is low and `elem_ack` changes neither the address nor the counts.
- R9: When `cfg_enable` is low, `busy` and `desc_req` fall on the next cycle, and `mem_addr`, `cur_x_count` and `cur_y_count` keep their values.
- R10: A 0-to-1 change of `cfg_enable` starts the engine: `busy`=1, `done`=0, the address is loaded from `cfg_start_addr`, and the counts are loaded. A programmed count of 0 loads the all-ones maximum (16'hFFFF).
- R11: After synchronous reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel enable; a rising edge starts the engine, and low aborts it |
| cfg_two_d | input | 1 | 1 = rows are stepped with the Y stride |
| cfg_flow | input | 2 | 0 = stop at the end; nonzero = request the next descriptor |
| cfg_irq_en | input | 1 | Enables the end-of-row interrupt pulse |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| cfg_start_addr | input | AW | Start address loaded on start and reload |
| cfg_x_count | input | CW | Elements per row (0 means maximum) |
| cfg_x_mod | input | MW | Signed X stride |
| cfg_y_count | input | CW | Rows (0 means maximum) |
| cfg_y_mod | input | MW | Signed Y stride |
| elem_req | output | 1 | Engine wants an element transfer |
| elem_ack | input | 1 | Element transfer accepted this cycle |
| mem_addr | output | AW | Current element address |
| mem_write | output | 1 | Direction latched at start or reload |
| cur_x_count | output | CW | Elements left in the current row |
| cur_y_count | output | CW | Rows left, including the current one |
| desc_req | output | 1 | Next descriptor wanted |
| desc_ack | input | 1 | Descriptor fetched; configuration inputs are valid |
| busy | output | 1 | Engine running |
| done | output | 1 | Work finished in stop mode |
| row_irq | output | 1 | One-cycle end-of-row interrupt |

## Verification
The bench drives a two-dimensional run whose row step would land 2 bytes off if the last X stride were left in or removed twice. A run with a negative stride catches a zero-extended modifier, which would send the address upward by 64K minus the stride. Acknowledges offered while a descriptor fetch is pending must not move the address or counts; a design that accepted them would run past the end of the row. Further cases are a zero programmed count, which must load the maximum rather than stop at once, and an abort in mid-row, which must freeze the counters rather than reload or clear them.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  // End-of-work behaviour; only FLOW_STOP ends the work, every other
  // value asks for a new descriptor.
  typedef enum logic [1:0] {
    FLOW_STOP       = 2'd0,
    FLOW_REPEAT     = 2'd1,
    FLOW_CHAIN      = 2'd2,
    FLOW_CHAIN_WIDE = 2'd3
  } flow_e;

endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       ack,
  input  logic       desc_ack,
  input  flow_e      flow,
  input  logic       two_d,
  input  logic       irq_en,
  input  logic       x_last,
  input  logic       y_more,
  output logic       run,
  output logic       done,
  output logic       pend,
  output logic       irq,
  output logic       load,
  output logic       step,
  output logic       row_next
);

  logic en_q;
  logic start;
  logic reload;
  logic row_end;
  logic finish;

  assign start    = enable & ~en_q;
  assign step     = enable & ~start & run & ~pend & ack;
  assign reload   = enable & ~start & pend & desc_ack;
  assign load     = start | reload;
  assign row_end  = step & x_last;
  assign row_next = row_end & two_d & y_more;
  assign finish   = row_end & ~row_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      run  <= 1'b0;
      done <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      en_q <= enable;
      irq  <= row_end & irq_en;
      if (!enable) begin
        run  <= 1'b0;
        pend <= 1'b0;
      end else if (start) begin
        run  <= 1'b1;
        done <= 1'b0;
        pend <= 1'b0;
      end else if (reload) begin
        pend <= 1'b0;
      end else if (finish) begin
        if (flow == FLOW_STOP) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          pend <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma2d_counts.sv
module dma2d_counts #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          row_next,
  input  logic [CW-1:0] cfg_x,
  input  logic [CW-1:0] cfg_y,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y,
  output logic          x_last,
  output logic          y_more
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // A programmed zero count means the largest count the field can hold.
  function automatic logic [CW-1:0] fill(input logic [CW-1:0] v);
    return (v == '0) ? '1 : v;
  endfunction

  assign x_last = (cur_x == ONE);
  assign y_more = (cur_y > ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_x <= '0;
      cur_y <= '0;
    end else if (load) begin
      cur_x <= fill(cfg_x);
      cur_y <= fill(cfg_y);
    end else if (row_next) begin
      cur_x <= fill(cfg_x);
      cur_y <= cur_y - ONE;
    end else if (step) begin
      cur_x <= cur_x - ONE;
    end
  end

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          row_next,
  input  logic [AW-1:0] start_addr,
  input  logic [MW-1:0] x_mod,
  input  logic [MW-1:0] y_mod,
  output logic [AW-1:0] cur_addr
);

  localparam int EXT = AW - MW;

  logic [AW-1:0] x_ext;
  logic [AW-1:0] y_ext;
  logic [AW-1:0] after_x;
  logic [AW-1:0] after_row;

  assign x_ext     = {{EXT{x_mod[MW-1]}}, x_mod};
  assign y_ext     = {{EXT{y_mod[MW-1]}}, y_mod};
  assign after_x   = cur_addr + x_ext;
  // The row step takes back the stride of the row's last element and
  // applies the row stride in its place.
  assign after_row = after_x - x_ext + y_ext;

  always_ff @(posedge clk) begin
    if (rst)           cur_addr <= '0;
    else if (load)     cur_addr <= start_addr;
    else if (row_next) cur_addr <= after_row;
    else if (step)     cur_addr <= after_x;
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_enable,
  input  logic          cfg_two_d,
  input  logic [1:0]    cfg_flow,
  input  logic          cfg_irq_en,
  input  logic          cfg_dir,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [CW-1:0] cfg_x_count,
  input  logic [MW-1:0] cfg_x_mod,
  input  logic [CW-1:0] cfg_y_count,
  input  logic [MW-1:0] cfg_y_mod,
  output logic          elem_req,
  input  logic          elem_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic [CW-1:0] cur_x_count,
  output logic [CW-1:0] cur_y_count,
  output logic          desc_req,
  input  logic          desc_ack,
  output logic          busy,
  output logic          done,
  output logic          row_irq
);

  logic run, pend, load, step, row_next, x_last, y_more;

  dma2d_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_enable),
    .ack      (elem_ack),
    .desc_ack (desc_ack),
    .flow     (flow_e'(cfg_flow)),
    .two_d    (cfg_two_d),
    .irq_en   (cfg_irq_en),
    .x_last   (x_last),
    .y_more   (y_more),
    .run      (run),
    .done     (done),
    .pend     (pend),
    .irq      (row_irq),
    .load     (load),
    .step     (step),
    .row_next (row_next)
  );

  dma2d_counts #(.CW(CW)) u_counts (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .row_next (row_next),
    .cfg_x    (cfg_x_count),
    .cfg_y    (cfg_y_count),
    .cur_x    (cur_x_count),
    .cur_y    (cur_y_count),
    .x_last   (x_last),
    .y_more   (y_more)
  );

  dma2d_addr #(.AW(AW), .MW(MW)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (step),
    .row_next   (row_next),
    .start_addr (cfg_start_addr),
    .x_mod      (cfg_x_mod),
    .y_mod      (cfg_y_mod),
    .cur_addr   (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)       mem_write <= 1'b0;
    else if (load) mem_write <= cfg_dir;
  end

  assign busy     = run;
  assign desc_req = pend;
  assign elem_req = run & ~pend;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32,
  parameter int MW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_enable,
  input logic          cfg_two_d,
  input logic          cfg_irq_en,
  input logic [MW-1:0] cfg_x_mod,
  input logic [MW-1:0] cfg_y_mod,
  input logic          elem_req,
  input logic          elem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] cur_x_count,
  input logic [CW-1:0] cur_y_count,
  input logic          desc_req,
  input logic          busy,
  input logic          done,
  input logic          row_irq
);

  localparam int EXT = AW - MW;
  localparam logic [CW-1:0] ONE = CW'(1);

  // R8
  no_elem_during_reload_chk: assert property (@(posedge clk) disable iff (rst)
    !(elem_req && desc_req));

  // R1
  x_stride_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && elem_req && elem_ack && cur_x_count > ONE) |=>
      (mem_addr == $past(mem_addr) + {{EXT{$past(cfg_x_mod[MW-1])}}, $past(cfg_x_mod)})
      && (cur_x_count == $past(cur_x_count) - ONE));

  // R3
  row_stride_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && cfg_two_d && elem_req && elem_ack && cur_x_count == ONE
     && cur_y_count > ONE) |=>
      (mem_addr == $past(mem_addr) + {{EXT{$past(cfg_y_mod[MW-1])}}, $past(cfg_y_mod)})
      && (cur_y_count == $past(cur_y_count) - ONE));

  // R2
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    row_irq |-> $past(cfg_enable && elem_req && elem_ack && cfg_irq_en
                      && cur_x_count == ONE));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && !desc_req));

  // R9
  abort_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (!busy && !desc_req && $stable(mem_addr)
                     && $stable(cur_x_count) && $stable(cur_y_count)));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .MW(MW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_enable  (cfg_enable),
  .cfg_two_d   (cfg_two_d),
  .cfg_irq_en  (cfg_irq_en),
  .cfg_x_mod   (cfg_x_mod),
  .cfg_y_mod   (cfg_y_mod),
  .elem_req    (elem_req),
  .elem_ack    (elem_ack),
  .mem_addr    (mem_addr),
  .cur_x_count (cur_x_count),
  .cur_y_count (cur_y_count),
  .desc_req    (desc_req),
  .busy        (busy),
  .done        (done),
  .row_irq     (row_irq)
);

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 0, cfg_two_d = 0, cfg_irq_en = 0, cfg_dir = 0;
  logic [1:0]  cfg_flow = 0;
  logic [31:0] cfg_start_addr = 0;
  logic [15:0] cfg_x_count = 0, cfg_x_mod = 0, cfg_y_count = 0, cfg_y_mod = 0;
  logic        elem_ack = 0, desc_ack = 0;
  logic        elem_req, mem_write, desc_req, busy, done, row_irq;
  logic [31:0] mem_addr;
  logic [15:0] cur_x_count, cur_y_count;

  int checks = 0;
  int bad = 0;
  int irq_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen dut (.*);

  // Behavioural reference state
  bit          m_run, m_done, m_pend, m_irq, m_enq, m_dir;
  logic [31:0] m_addr;
  int unsigned m_x, m_y;

  function automatic int unsigned fillc(input logic [15:0] v);
    return (v == 0) ? 65535 : int'(v);
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return 32'(signed'(v));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_done = 0; m_pend = 0; m_irq = 0; m_enq = 0; m_dir = 0;
      m_addr = 0; m_x = 0; m_y = 0;
    end else begin
      m_irq = 0;
      if (!cfg_enable) begin
        m_run = 0; m_pend = 0;
      end else if (!m_enq || (m_pend && desc_ack)) begin
        if (!m_enq) begin m_run = 1; m_done = 0; end
        m_pend = 0;
        m_addr = cfg_start_addr; m_x = fillc(cfg_x_count); m_y = fillc(cfg_y_count);
        m_dir = cfg_dir;
      end else if (m_run && !m_pend && elem_ack) begin
        if (m_x == 1) begin
          m_irq = cfg_irq_en;
          if (cfg_two_d && m_y > 1) begin
            m_y = m_y - 1; m_x = fillc(cfg_x_count); m_addr = m_addr + sx(cfg_y_mod);
          end else begin
            m_x = 0; m_addr = m_addr + sx(cfg_x_mod);
            if (cfg_flow == 0) begin m_run = 0; m_done = 1; end
            else m_pend = 1;
          end
        end else begin
          m_x = m_x - 1; m_addr = m_addr + sx(cfg_x_mod);
        end
      end
      m_enq = cfg_enable;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 mem_addr", mem_addr, m_addr);
      check("R1 cur_x_count", 32'(cur_x_count), m_x);
      check("R3 cur_y_count", 32'(cur_y_count), m_y);
      check("R2 row_irq", 32'(row_irq), 32'(m_irq));
      check("R4 done", 32'(done), 32'(m_done));
      check("R4 busy", 32'(busy), 32'(m_run));
      check("R5 desc_req", 32'(desc_req), 32'(m_pend));
      check("R8 elem_req", 32'(elem_req), 32'(m_run && !m_pend));
      check("R6 mem_write", 32'(mem_write), 32'(m_dir));
      if (row_irq) irq_seen++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      elem_ack = (gap == 0) || (i % (gap + 1) == 0);
      @(negedge clk);
    end
    elem_ack = 0;
  endtask

  initial begin
    cyc(3);
    // R11 reset state
    check("R11 mem_addr", mem_addr, 0);
    check("R11 flags", {27'd0, busy, done, desc_req, elem_req, row_irq}, 0);
    rst = 0;
    cyc(1);

    // One-dimensional stop run
    cfg_start_addr = 32'h1000; cfg_x_count = 4; cfg_x_mod = 4; cfg_flow = 0;
    cfg_irq_en = 1; cfg_dir = 1; cfg_enable = 1;
    cyc(1);
    check("R10 started", {31'd0, busy}, 1);
    acks(6, 0);
    cyc(2);
    check("R4 end addr", mem_addr, 32'h1010);
    check("R4 done flag", {31'd0, done}, 1);

    // Two-dimensional stop run
    cfg_enable = 0; cyc(1);
    check("R4 done held", {31'd0, done}, 1);
    irq_seen = 0;
    cfg_start_addr = 32'h2000; cfg_x_count = 3; cfg_x_mod = 2;
    cfg_y_count = 3; cfg_y_mod = 16'h0040; cfg_two_d = 1; cfg_enable = 1;
    cyc(1);
    acks(20, 1);
    cyc(2);
    check("R3 end addr", mem_addr, 32'h208E);
    check("R2 irq count", 32'(irq_seen), 3);

    // Negative stride, repeat flow, reload
    cfg_enable = 0; cyc(1);
    cfg_start_addr = 32'h3000; cfg_x_count = 2; cfg_x_mod = 16'hFFFC;
    cfg_y_count = 0; cfg_two_d = 0; cfg_flow = 1; cfg_irq_en = 0; cfg_enable = 1;
    cyc(1);
    check("R10 zero y fill", 32'(cur_y_count), 32'h0000FFFF);
    acks(2, 0);
    cyc(1);
    check("R7 neg addr", mem_addr, 32'h2FF8);
    check("R5 desc_req", {31'd0, desc_req}, 1);
    acks(3, 0);
    cyc(1);
    check("R8 addr frozen", mem_addr, 32'h2FF8);
    check("R8 x frozen", 32'(cur_x_count), 0);
    cfg_start_addr = 32'h4000; cfg_x_count = 0; cfg_dir = 0; desc_ack = 1;
    cyc(1);
    desc_ack = 0;
    cyc(1);
    check("R10 zero x fill", 32'(cur_x_count), 32'h0000FFFF);
    check("R5 reload addr", mem_addr, 32'h4000);
    check("R6 dir", {31'd0, mem_write}, 0);

    // Abort mid-row
    acks(5, 0);
    cyc(1);
    check("R1 mid addr", mem_addr, 32'h3FEC);
    cfg_enable = 0; elem_ack = 1;
    cyc(3);
    elem_ack = 0;
    check("R9 addr kept", mem_addr, 32'h3FEC);
    check("R9 x kept", 32'(cur_x_count), 32'h0000FFFA);
    check("R9 idle", {30'd0, busy, desc_req}, 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule